// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block produces the single output pin of one timer capture/compare channel. It receives two compare-match strobes, each one timer-clock cycle wide. The first is the channel's own match. The second is the period match raised by channel 0. A 3-bit mode word selects how those strobes shape the output. The output can be a direct copy of a software-written bit, a level that is set, cleared or inverted by the channel match, or a pulse-width-modulated waveform. In the PWM modes the channel match forms one edge of the waveform and the period match forms the other.

Every mode except the direct mode acts through a single output flip-flop clocked by the timer clock. The direct mode is a combinational path from the software bit to the pin. While the direct mode is selected, the flip-flop follows the software bit. When software switches to a match-driven mode, the waveform therefore starts from the level the pin already had. The counter and the comparators sit outside this block.

Top module: `pwm_outmode_unit`

## Requirements
- R1: While `rst_n` is low the output flip-flop is 0, so a non-direct mode shows 0 on `out_sig` during reset and in the first cycle after it.
- R2: With `mode_sel` = 0 (direct), `out_sig` equals `sw_out_bit` in the same cycle, with no clock edge needed.
- R3: With `mode_sel` = 1, a cycle with `chan_match` high makes `out_sig` 1 after the next rising edge; `period_match` has no effect.
- R4: With `mode_sel` = 5, a cycle with `chan_match` high makes `out_sig` 0 after the next rising edge; `period_match` has no effect.
- R5: With `mode_sel` = 4, every cycle with `chan_match` high inverts `out_sig` at the next rising edge; `period_match` has no effect.
- R6: With `mode_sel` = 2, `chan_match` inverts the output and `period_match` clears it.
- R7: With `mode_sel` = 3, `chan_match` sets the output and `period_match` clears it.
- R8: With `mode_sel` = 6, `chan_match` inverts the output and `period_match` sets it.
- R9: With `mode_sel` = 7, `chan_match` clears the output and `period_match` sets it.
- R10: In modes 2, 3, 6 and 7, when both strobes are high in the same cycle, only the `period_match` action is applied.
- R11: In modes 1 to 7, `out_sig` changes only at a rising edge of `clk_tmr`, and it holds its level across any edge that has no effective strobe. Changing `sw_out_bit` in these modes has no effect.
- R12: While `mode_sel` = 0, the output flip-flop loads `sw_out_bit` on every edge. After a switch to a non-direct mode, the output starts at the last software level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tmr | input | 1 | Timer clock; the output flip-flop updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the output flip-flop |
| mode_sel | input | 3 | Output mode select, encodings 0 to 7 as in the requirements |
| sw_out_bit | input | 1 | Software-written output level used by the direct mode |
| chan_match | input | 1 | One-cycle compare-match strobe of this channel |
| period_match | input | 1 | One-cycle period-match strobe from channel 0 |
| out_sig | output | 1 | Channel output pin |

## Verification
Each mode is driven with isolated channel strobes, isolated period strobes and coincident pairs. Isolated strobes show whether set, clear and invert are bound to the correct strobe. The unused strobe in modes 1, 4 and 5 exposes a mode that reacts when it should not. Coincident pairs separate the priority order from the reverse order, and quiet stretches in which only the software bit changes expose leakage from the direct path into the registered modes. A long pseudo-random stretch mixes modes and strobes, including switches into and out of the direct mode, to test the hand-over of the software level.

// File: rtl/outmode_pkg.sv
package outmode_pkg;

  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    OM_DIRECT  = 3'd0,
    OM_SET     = 3'd1,
    OM_TGL_CLR = 3'd2,
    OM_SET_CLR = 3'd3,
    OM_TGL     = 3'd4,
    OM_CLR     = 3'd5,
    OM_TGL_SET = 3'd6,
    OM_CLR_SET = 3'd7
  } outmode_e;

  typedef enum logic [2:0] {
    ACT_HOLD = 3'd0,
    ACT_SET  = 3'd1,
    ACT_CLR  = 3'd2,
    ACT_TGL  = 3'd3,
    ACT_LOAD = 3'd4
  } act_e;

  // Map a mode and the two strobes to one action; the period strobe wins in PWM modes.
  function automatic act_e strobe_action(outmode_e m, logic own, logic per);
    act_e a;
    a = ACT_HOLD;
    case (m)
      OM_DIRECT:  a = ACT_LOAD;
      OM_SET:     a = own ? ACT_SET : ACT_HOLD;
      OM_CLR:     a = own ? ACT_CLR : ACT_HOLD;
      OM_TGL:     a = own ? ACT_TGL : ACT_HOLD;
      OM_TGL_CLR: a = per ? ACT_CLR : (own ? ACT_TGL : ACT_HOLD);
      OM_SET_CLR: a = per ? ACT_CLR : (own ? ACT_SET : ACT_HOLD);
      OM_TGL_SET: a = per ? ACT_SET : (own ? ACT_TGL : ACT_HOLD);
      OM_CLR_SET: a = per ? ACT_SET : (own ? ACT_CLR : ACT_HOLD);
      default:    a = ACT_HOLD;
    endcase
    return a;
  endfunction

  // Next level of the output flip-flop for a given action.
  function automatic logic apply_action(act_e a, logic cur, logic sw);
    logic n;
    case (a)
      ACT_SET:  n = 1'b1;
      ACT_CLR:  n = 1'b0;
      ACT_TGL:  n = ~cur;
      ACT_LOAD: n = sw;
      default:  n = cur;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/outmode_decode.sv
module outmode_decode
  import outmode_pkg::*;
(
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              chan_match,
  input  logic              period_match,
  output act_e              act
);
  outmode_e mode_e;

  always_comb begin
    mode_e = outmode_e'(mode_sel);
    act    = strobe_action(mode_e, chan_match, period_match);
  end
endmodule

// File: rtl/outmode_state.sv
module outmode_state
  import outmode_pkg::*;
#(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk_tmr,
  input  logic rst_n,
  input  act_e act,
  input  logic sw_out_bit,
  output logic level_q
);
  logic level_d;

  always_comb level_d = apply_action(act, level_q, sw_out_bit);

  always_ff @(posedge clk_tmr or negedge rst_n) begin
    if (!rst_n) level_q <= RST_LEVEL;
    else        level_q <= level_d;
  end
endmodule

// File: rtl/outmode_select.sv
module outmode_select
  import outmode_pkg::*;
(
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              sw_out_bit,
  input  logic              level_q,
  output logic              out_sig
);
  logic direct_sel;

  always_comb begin
    direct_sel = (outmode_e'(mode_sel) == OM_DIRECT);
    out_sig    = direct_sel ? sw_out_bit : level_q;
  end
endmodule

// File: rtl/pwm_outmode_unit.sv
module pwm_outmode_unit
  import outmode_pkg::*;
#(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic              clk_tmr,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              sw_out_bit,
  input  logic              chan_match,
  input  logic              period_match,
  output logic              out_sig
);
  act_e act;
  logic state_q;

  outmode_decode u_decode (
    .mode_sel     (mode_sel),
    .chan_match   (chan_match),
    .period_match (period_match),
    .act          (act)
  );

  outmode_state #(.RST_LEVEL(RST_LEVEL)) u_state (
    .clk_tmr    (clk_tmr),
    .rst_n      (rst_n),
    .act        (act),
    .sw_out_bit (sw_out_bit),
    .level_q    (state_q)
  );

  outmode_select u_select (
    .mode_sel   (mode_sel),
    .sw_out_bit (sw_out_bit),
    .level_q    (state_q),
    .out_sig    (out_sig)
  );
endmodule

// File: rtl/outmode_chk.sv
module outmode_chk (
  input logic       clk_tmr,
  input logic       rst_n,
  input logic [2:0] mode_sel,
  input logic       sw_out_bit,
  input logic       chan_match,
  input logic       period_match,
  input logic       out_sig,
  input logic       state_q
);
  AST_RESET_LOW: assert property (@(posedge clk_tmr) $rose(rst_n) |-> !state_q); // R1
  AST_SET_ON_MATCH: assert property (@(posedge clk_tmr) disable iff (!rst_n)
    (mode_sel == 3'd1 && chan_match) |=> (state_q && (mode_sel == 3'd0 || out_sig))); // R3
  AST_CLR_ON_MATCH: assert property (@(posedge clk_tmr) disable iff (!rst_n)
    (mode_sel == 3'd5 && chan_match) |=> !state_q); // R4
  AST_TGL_ON_MATCH: assert property (@(posedge clk_tmr) disable iff (!rst_n)
    (mode_sel == 3'd4 && chan_match) |=> (state_q != $past(state_q))); // R5
  AST_PERIOD_CLR_WINS: assert property (@(posedge clk_tmr) disable iff (!rst_n)
    ((mode_sel == 3'd2 || mode_sel == 3'd3) && period_match) |=> !state_q); // R10
  AST_PERIOD_SET_WINS: assert property (@(posedge clk_tmr) disable iff (!rst_n)
    ((mode_sel == 3'd6 || mode_sel == 3'd7) && period_match) |=> state_q); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk_tmr) disable iff (!rst_n)
    (mode_sel != 3'd0 && !chan_match && !period_match) |=> $stable(state_q)); // R11
  AST_DIRECT_LOAD: assert property (@(posedge clk_tmr) disable iff (!rst_n)
    (mode_sel == 3'd0) |=> (state_q == $past(sw_out_bit))); // R12
endmodule

bind pwm_outmode_unit outmode_chk chk_i (.*);

// File: tb/pwm_outmode_unit_tb.sv
`timescale 1ns/1ps
module pwm_outmode_unit_tb_top;
  logic       clk_tmr = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'd1;
  logic       sw_out_bit = 1'b0;
  logic       chan_match = 1'b0;
  logic       period_match = 1'b0;
  logic       out_sig;

  int    n_checks = 0;
  int    n_fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    ref_lvl = 0;

  always #2.5 clk_tmr = ~clk_tmr;

  pwm_outmode_unit dut_i (
    .clk_tmr(clk_tmr), .rst_n(rst_n), .mode_sel(mode_sel), .sw_out_bit(sw_out_bit),
    .chan_match(chan_match), .period_match(period_match), .out_sig(out_sig)
  );

  // Behavioural model of the output level, written from the requirements.
  always @(posedge clk_tmr or negedge rst_n) begin
    if (!rst_n) ref_lvl <= 0;
    else begin
      int m;
      int nxt;
      m = mode_sel;
      nxt = ref_lvl;
      if (m == 0) nxt = sw_out_bit;
      else if ((m == 2 || m == 3) && period_match) nxt = 0;
      else if ((m == 6 || m == 7) && period_match) nxt = 1;
      else if (chan_match) begin
        if (m == 1 || m == 3) nxt = 1;
        else if (m == 5 || m == 7) nxt = 0;
        else nxt = 1 - ref_lvl;
      end
      ref_lvl <= nxt;
    end
  end

  function automatic int expect_out();
    return (mode_sel == 3'd0) ? int'(sw_out_bit) : ref_lvl;
  endfunction

  task automatic compare(input string req);
    n_checks++;
    if (int'(out_sig) != expect_out()) begin
      n_fails++;
      $display("FAIL %s: out_sig=%0d expected=%0d (mode %0d)", req, out_sig, expect_out(), mode_sel);
    end
  endtask

  // Compare the result of the previous cycle's inputs, then apply new ones.
  task automatic step(input int m, input bit s, input bit c, input bit p, input string req);
    @(negedge clk_tmr);
    compare(cur_req);
    mode_sel = 3'(m); sw_out_bit = s; chan_match = c; period_match = p;
    cur_req = req;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    // R1: reset holds the flip-flop low, including a strobe during reset
    step(1, 1, 1, 0, "R1");
    step(1, 1, 0, 0, "R1");
    rst_n = 1'b1;
    step(1, 1, 0, 0, "R1");
    step(1, 1, 0, 0, "R11");
    // R2: direct mode follows the software bit without a clock edge
    step(0, 1, 0, 0, "R2");
    #1; compare("R2");
    sw_out_bit = 1'b0; #1; compare("R2");
    sw_out_bit = 1'b1; #1; compare("R2");
    step(0, 1, 1, 1, "R12");
    // R12: leave direct mode with software level 1, then 0
    step(4, 0, 0, 0, "R12");
    step(4, 0, 0, 0, "R11");
    step(0, 0, 0, 0, "R12");
    step(1, 1, 0, 0, "R12");
    // R3: set mode, period strobe ignored
    step(1, 1, 0, 1, "R3");
    step(1, 0, 1, 0, "R3");
    step(1, 0, 1, 1, "R3");
    // R4: clear mode
    step(5, 1, 0, 1, "R4");
    step(5, 1, 1, 0, "R4");
    step(5, 0, 0, 1, "R4");
    // R5: toggle mode
    for (int i = 0; i < 5; i++) step(4, 1, (i != 2), (i == 3), "R5");
    // R6: toggle/clear
    step(2, 0, 1, 0, "R6"); step(2, 0, 1, 0, "R6"); step(2, 0, 1, 0, "R6");
    step(2, 0, 0, 1, "R6"); step(2, 0, 1, 0, "R10"); step(2, 0, 1, 1, "R10");
    // R7: set/clear
    step(3, 0, 1, 0, "R7"); step(3, 0, 0, 1, "R7"); step(3, 0, 1, 0, "R10");
    step(3, 0, 1, 1, "R10");
    // R11: software bit changes have no effect in a registered mode
    step(3, 1, 0, 0, "R11"); step(3, 0, 0, 0, "R11"); step(3, 1, 0, 0, "R11");
    // R8: toggle/set
    step(6, 0, 0, 1, "R8"); step(6, 0, 1, 0, "R8"); step(6, 0, 1, 0, "R8");
    step(6, 0, 1, 0, "R10"); step(6, 0, 1, 1, "R10");
    // R9: clear/set
    step(7, 0, 1, 0, "R9"); step(7, 0, 0, 1, "R9"); step(7, 0, 1, 0, "R10");
    step(7, 0, 1, 1, "R10");
    step(7, 0, 0, 0, "R11");
    // Mixed stretch covering R6, R7, R8, R9 and R12 hand-over
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[2:0]), lfsr[5], lfsr[7], lfsr[9] & lfsr[3], "R6_R7_R8_R9_R12");
    end
    step(7, 0, 0, 0, "R11");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule